// File: doc/BRIEF.md
# Receive FIFO with Programmable Level Flags

A synchronous word-wide receive buffer that sits between a parallel input port and a register read path. Words offered on the input port are stored only while the receive enable is high. The reader takes one word per read strobe from what behaves like a single data register read again and again. A packed threshold register sets two levels. The almost-empty level sits in the low half. The almost-full margin sits in the upper half, starting at bit 16.

The status word reports the four fill levels as inverted ("not") flags, so a set bit means the condition is absent. Overrun and underrun are latched error bits. Writing a one to an error bit's position clears it. The block also exposes the current word count and the buffer capacity, both 20 bits wide, and a clear input that empties the buffer.

Top module: `rx_level_fifo`

## Requirements
- R1: After reset the buffer is empty, both error bits are clear, rd_data_o is zero and the thresholds take their reset parameters, so with defaults status_o equals 32'h0000_C000.
- R2: A word on wr_data_i is stored when wr_valid_i and rx_enable_i are both high and the buffer is not full. level_o rises by one after that clock edge.
- R3: When rx_enable_i is low, wr_valid_i has no effect. level_o does not change and neither error bit is set.
- R4: Words leave in arrival order. On a read strobe to a non-empty buffer, rd_data_o shows the oldest word after that clock edge.
- R5: An enabled write to a full buffer is dropped and sets the overrun bit, status_o[23]. level_o never exceeds DEPTH.
- R6: A read strobe to an empty buffer leaves rd_data_o unchanged and sets the underrun bit, status_o[22].
- R7: Writing err_clr_i with err_clr_data_i bit 22 or bit 23 set clears that error bit. Other bit positions have no effect. When an error event and its clear happen in the same cycle, the bit stays set.
- R8: thr_wr_i loads the almost-empty level from thr_data_i[15:0] and the almost-full margin from thr_data_i[31:16]. Almost-empty holds when level <= level_ae. Almost-full holds when level + margin >= DEPTH.
- R9: status_o bit 12 is not-empty, bit 13 is not-almost-empty, bit 14 is not-almost-full and bit 15 is not-full. Bits 22 and 23 are the error bits. All other bits read zero.
- R10: clear_i empties the buffer at the next edge and overrides any read or write in that cycle. It leaves the error bits and rd_data_o unchanged.
- R11: level_o always equals the number of stored words, and size_o always equals DEPTH.
- R12: A read and an enabled write in the same cycle to a buffer that is neither empty nor full both take effect, and level_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_enable_i | input | 1 | Gates writes from the input port |
| wr_valid_i | input | 1 | Input port word valid |
| wr_data_i | input | 32 | Input port word |
| rd_i | input | 1 | Read strobe: pop one word |
| rd_data_o | output | 32 | Last word read |
| clear_i | input | 1 | Empty the buffer |
| thr_wr_i | input | 1 | Load the threshold register |
| thr_data_i | input | 32 | Threshold value: [15:0] almost-empty level, [31:16] almost-full margin |
| err_clr_i | input | 1 | Write strobe for clearing error bits |
| err_clr_data_i | input | 32 | Write-one-to-clear mask, bits 22 and 23 |
| status_o | output | 32 | Flag and error status word |
| level_o | output | 20 | Stored word count |
| size_o | output | 20 | Capacity in words |

## Verification
On every cycle, the in-line assertions check that the count stays within capacity and moves by exactly one for a lone push or pop. They also check that a full-buffer write raises overrun, that an empty read raises underrun and freezes the read data, and that a clear empties the buffer. Only the bench's scenarios can show first-in first-out ordering, where the threshold flags switch for given register values, the write-one-to-clear masking with the set-wins collision, and the gating by the receive enable. The bench does this by comparing every output against a queue model on every cycle.

// File: rtl/rx_level_fifo_pkg.sv
package rx_level_fifo_pkg;
  localparam int unsigned ST_NEMPTY  = 12;
  localparam int unsigned ST_NAEMPTY = 13;
  localparam int unsigned ST_NAFULL  = 14;
  localparam int unsigned ST_NFULL   = 15;
  localparam int unsigned ST_UNDER   = 22;
  localparam int unsigned ST_OVER    = 23;
  localparam int unsigned THR_W      = 16;
  localparam int unsigned LVL_W      = 20;

  typedef struct packed {
    logic full;
    logic afull;
    logic aempty;
    logic empty;
  } lvl_flags_t;
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [AW-1:0]     wptr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  input  logic [AW-1:0]     rptr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (pop_i) rdata_q <= mem_q[rptr_i];
  end

  assign rdata_o = rdata_q;

  // R6: output register only moves on an accepted pop
  a_r6_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> $stable(rdata_q));
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_req_i,
  input  logic          pop_req_i,
  input  logic          clr_over_i,
  input  logic          clr_under_i,
  output logic          push_o,
  output logic          pop_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] count_o,
  output logic          over_o,
  output logic          under_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          over_q, under_q;
  logic          is_full, is_empty, over_ev, under_ev;

  assign is_full  = (count_q == FULL_CNT);
  assign is_empty = (count_q == '0);
  assign push_o   = push_req_i && !clear_i && !is_full;
  assign pop_o    = pop_req_i && !clear_i && !is_empty;
  assign over_ev  = push_req_i && !clear_i && is_full;
  assign under_ev = pop_req_i && !clear_i && is_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (clear_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_o) wptr_q <= (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
      if (pop_o)  rptr_q <= (rptr_q == LAST_PTR) ? '0 : rptr_q + 1'b1;
      unique case ({push_o, pop_o})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // sticky errors: a new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      over_q  <= over_ev  | (over_q  & ~clr_over_i);
      under_q <= under_ev | (under_q & ~clr_under_i);
    end
  end

  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign count_o = count_q;
  assign over_o  = over_q;
  assign under_o = under_q;

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);
  a_r2_count_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_i && !pop_req_i && !clear_i && count_q < FULL_CNT)
      |=> count_q == $past(count_q) + 1'b1);
  a_r4_count_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req_i && !push_req_i && !clear_i && count_q != '0)
      |=> count_q == $past(count_q) - 1'b1);
  a_r5_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_i && !clear_i && count_q == FULL_CNT) |=> over_q);
  a_r6_underrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req_i && !clear_i && count_q == '0) |=> under_q);
  a_r10_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_q == '0);
endmodule

// File: rtl/rx_fifo_flags.sv
module rx_fifo_flags
  import rx_level_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned SW = ((THR_W > CW) ? THR_W : CW) + 1
) (
  input  logic [CW-1:0]    count_i,
  input  logic [THR_W-1:0] ae_lvl_i,
  input  logic [THR_W-1:0] af_margin_i,
  output lvl_flags_t       flags_o
);
  logic [SW-1:0] cnt_x, ae_x, af_x, depth_x;

  assign cnt_x   = SW'(count_i);
  assign ae_x    = SW'(ae_lvl_i);
  assign af_x    = SW'(af_margin_i);
  assign depth_x = SW'(DEPTH);

  always_comb begin
    flags_o.empty  = (cnt_x == '0);
    flags_o.full   = (cnt_x == depth_x);
    flags_o.aempty = (cnt_x <= ae_x);
    flags_o.afull  = ((cnt_x + af_x) >= depth_x);
  end
endmodule

// File: rtl/rx_level_fifo.sv
module rx_level_fifo
  import rx_level_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned AE_RST = 4,
  parameter int unsigned AF_RST = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_enable_i,
  input  logic        wr_valid_i,
  input  logic [31:0] wr_data_i,
  input  logic        rd_i,
  output logic [31:0] rd_data_o,
  input  logic        clear_i,
  input  logic        thr_wr_i,
  input  logic [31:0] thr_data_i,
  input  logic        err_clr_i,
  input  logic [31:0] err_clr_data_i,
  output logic [31:0] status_o,
  output logic [19:0] level_o,
  output logic [19:0] size_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [THR_W-1:0] ae_q, af_q;
  logic             push, pop, over, under;
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  lvl_flags_t       flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q <= THR_W'(AE_RST);
      af_q <= THR_W'(AF_RST);
    end else if (thr_wr_i) begin
      ae_q <= thr_data_i[THR_W-1:0];
      af_q <= thr_data_i[2*THR_W-1:THR_W];
    end
  end

  rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .push_req_i  (wr_valid_i & rx_enable_i),
    .pop_req_i   (rd_i),
    .clr_over_i  (err_clr_i & err_clr_data_i[ST_OVER]),
    .clr_under_i (err_clr_i & err_clr_data_i[ST_UNDER]),
    .push_o      (push),
    .pop_o       (pop),
    .wptr_o      (wptr),
    .rptr_o      (rptr),
    .count_o     (count),
    .over_o      (over),
    .under_o     (under)
  );

  rx_fifo_store #(.DATA_W(32), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wptr_i  (wptr),
    .wdata_i (wr_data_i),
    .pop_i   (pop),
    .rptr_i  (rptr),
    .rdata_o (rd_data_o)
  );

  rx_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .count_i     (count),
    .ae_lvl_i    (ae_q),
    .af_margin_i (af_q),
    .flags_o     (flags)
  );

  always_comb begin
    status_o             = '0;
    status_o[ST_NEMPTY]  = ~flags.empty;
    status_o[ST_NAEMPTY] = ~flags.aempty;
    status_o[ST_NAFULL]  = ~flags.afull;
    status_o[ST_NFULL]   = ~flags.full;
    status_o[ST_UNDER]   = under;
    status_o[ST_OVER]    = over;
  end

  assign level_o = LVL_W'(count);
  assign size_o  = LVL_W'(DEPTH);

  // R3: gated writes never move the level
  a_r3_gated_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_enable_i && !rd_i && !clear_i) |=> $stable(level_o));
  // R9: full and empty are never reported together
  a_r9_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_NEMPTY] || status_o[ST_NFULL]);
endmodule

// File: tb/rx_level_fifo_bench.sv
module rx_level_fifo_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_enable_i = 1'b0, wr_valid_i = 1'b0, rd_i = 1'b0;
  logic        clear_i = 1'b0, thr_wr_i = 1'b0, err_clr_i = 1'b0;
  logic [31:0] wr_data_i = '0, thr_data_i = '0, err_clr_data_i = '0;
  logic [31:0] rd_data_o, status_o;
  logic [19:0] level_o, size_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] q[$];
  logic [15:0] m_ae = 16'd4, m_af = 16'd4;
  logic        m_or = 1'b0, m_ur = 1'b0;
  logic [31:0] m_rd = '0;

  always #4 clk = ~clk;

  rx_level_fifo #(.DEPTH(DEPTH)) u_rx_level_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .rx_enable_i(rx_enable_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .rd_i(rd_i),
    .rd_data_o(rd_data_o), .clear_i(clear_i), .thr_wr_i(thr_wr_i),
    .thr_data_i(thr_data_i), .err_clr_i(err_clr_i),
    .err_clr_data_i(err_clr_data_i), .status_o(status_o),
    .level_o(level_o), .size_o(size_o)
  );

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    int n;
    n = q.size();
    s = '0;
    s[12] = (n != 0);
    s[13] = !(n <= int'(m_ae));
    s[14] = !((n + int'(m_af)) >= DEPTH);
    s[15] = (n != DEPTH);
    s[22] = m_ur;
    s[23] = m_or;
    return s;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "status", status_o, exp_status());
    chk(tag, "level R11", {12'd0, level_o}, q.size());
    chk(tag, "rd_data", rd_data_o, m_rd);
    chk("R11", "size", {12'd0, size_o}, DEPTH);
  endtask

  task automatic model_edge();
    bit full, empty;
    full  = (q.size() == DEPTH);
    empty = (q.size() == 0);
    if (thr_wr_i) begin
      m_ae = thr_data_i[15:0];
      m_af = thr_data_i[31:16];
    end
    if (err_clr_i && err_clr_data_i[22]) m_ur = 1'b0;
    if (err_clr_i && err_clr_data_i[23]) m_or = 1'b0;
    if (clear_i) q.delete();
    else begin
      if (rd_i) begin
        if (empty) m_ur = 1'b1;
        else m_rd = q.pop_front();
      end
      if (wr_valid_i && rx_enable_i) begin
        if (full) m_or = 1'b1;
        else q.push_back(wr_data_i);
      end
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    rx_enable_i = 0; wr_valid_i = 0; rd_i = 0; clear_i = 0;
    thr_wr_i = 0; err_clr_i = 0; err_clr_data_i = '0;
  endtask

  task automatic push(input logic [31:0] d, input logic en);
    wr_valid_i = 1; rx_enable_i = en; wr_data_i = d;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "status", status_o, 32'h0000_C000);
    compare("R1");

    // R8 thresholds: ae=2, af margin=3
    thr_wr_i = 1; thr_data_i = {16'd3, 16'd2}; tick("R8");
    for (int i = 0; i < 5; i++) begin push(32'hA000_0000 + i, 1); tick("R2"); end
    for (int i = 0; i < 3; i++) begin push(32'hDEAD_0000 + i, 0); tick("R3"); end
    for (int i = 0; i < 4; i++) begin
      push(32'hB000_0000 + i, 1); rd_i = 1; tick("R12");
    end
    for (int i = 0; i < 15; i++) begin push(32'hC000_0000 + i, 1); tick("R5"); end
    chk("R5", "overrun bit", {31'd0, status_o[23]}, 1);
    for (int i = 0; i < 16; i++) begin rd_i = 1; tick("R4"); end
    for (int i = 0; i < 2; i++) begin rd_i = 1; tick("R6"); end
    chk("R6", "underrun bit", {31'd0, status_o[22]}, 1);
    // R7: clear only underrun, unrelated bits ignored
    err_clr_i = 1; err_clr_data_i = 32'h0040_0FFF; tick("R7");
    chk("R7", "err bits", {30'd0, status_o[23:22]}, 2'b10);
    // R7 collision: underrun event and its clear together
    rd_i = 1; err_clr_i = 1; err_clr_data_i = 32'h00C0_0000; tick("R7");
    chk("R7", "err bits", {30'd0, status_o[23:22]}, 2'b01);
    err_clr_i = 1; err_clr_data_i = 32'h00C0_0000; tick("R7");
    for (int i = 0; i < 5; i++) begin push(32'hE000_0000 + i, 1); tick("R10"); end
    clear_i = 1; push(32'hF00D_F00D, 1); rd_i = 1; tick("R10");
    chk("R10", "level", {12'd0, level_o}, 0);

    // R11 random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      wr_valid_i = ($urandom_range(0, 99) < 55);
      rx_enable_i = ($urandom_range(0, 9) != 0);
      wr_data_i = $urandom();
      rd_i = ($urandom_range(0, 99) < 45);
      clear_i = (r == 0);
      if (r >= 1 && r < 3) begin
        thr_wr_i = 1;
        thr_data_i = {16'($urandom_range(0, 20)), 16'($urandom_range(0, 20))};
      end
      if (r >= 3 && r < 6) begin
        err_clr_i = 1; err_clr_data_i = $urandom();
      end
      tick("R11");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule